// File: doc/BRIEF.md
# Receive Strip Buffer with Address Filter

This block sits behind the receive bit decoder of a serial frame receiver. Once the preamble and the begin-of-frame marker have been recognised, a one-cycle `bof_i` pulse announces a new frame. Each later decoded bit arrives on `bit_i`, qualified by `bit_valid_i`. Every accepted bit enters a serial strip buffer. The buffer is as long as the selected check code: 16 bits, or 32 bits when `crc_long_i` is high. A bit leaves the buffer only when a newer bit pushes it out. As a result, the check-code bits at the tail of a frame never leave the buffer.

The first eight bits of the frame form the address. They are compared against a programmable station address and against the all-ones broadcast value as soon as they sit at the head of the buffer. On a match, the bits leaving the buffer are packed into bytes, least significant bit first. Each completed byte is written to the receive FIFO with a one-cycle strobe. A sticky flag reports that the first byte has reached the FIFO; collision handling uses it to tell an early abort from a receive error. On a mismatch, the frame is dropped. An abort input clears the frame state.

Top module: `rx_strip_filter`

## Requirements
- R1: After reset, `fifo_wr_o`, `fifo_data_o`, `addr_match_o` and `first_byte_o` are all zero, and bits are ignored until a `bof_i` pulse.
- R2: With `crc_long_i` low, the first bit accepted after `bof_i` is the first bit to leave the 16-bit buffer. The first FIFO write is seen in the clock after the 24th accepted bit.
- R3: A written byte holds eight consecutive buffer-exit bits, with the earliest bit in data bit 0. Bytes are written in arrival order, and two writes are never on adjacent cycles.
- R4: The address is the first eight frame bits, with the first bit as bit 0. `addr_match_o` is 1 by the second clock after the eighth bit is accepted, exactly when the address equals `station_addr_i` or 8'hFF. It then holds until `bof_i` or `abort_i`.
- R5: When the address does not match, no FIFO write occurs until the next `bof_i`.
- R6: The last 16 (or 32) bits of a frame are never written. A matched frame of 8·N bits plus the check code yields exactly N writes.
- R7: With `crc_long_i` high, the buffer is 32 bits long and the first FIFO write is seen in the clock after the 40th accepted bit.
- R8: `first_byte_o` rises together with the first FIFO write of a frame and stays high until `bof_i` or `abort_i`.
- R9: `abort_i` clears the buffer, the byte register, `addr_match_o` and `first_byte_o` at the next clock. Later bits cause no write until a new `bof_i`.
- R10: Cycles with `bit_valid_i` low change no state, and gaps between bits do not alter the written bytes.
- R11: A `bof_i` pulse in the middle of a frame discards it and restarts reception with the following bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bof_i | input | 1 | One-cycle pulse: a new frame follows |
| abort_i | input | 1 | Abort the current frame |
| crc_long_i | input | 1 | 0: 16-bit buffer, 1: 32-bit buffer; hold for the whole frame |
| station_addr_i | input | 8 | Station address to accept |
| bit_i | input | 1 | Decoded receive bit |
| bit_valid_i | input | 1 | `bit_i` is valid this cycle |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | Byte to write |
| addr_match_o | output | 1 | Frame address accepted |
| first_byte_o | output | 1 | First byte of the frame written |

## Verification
A wrong fill count or the wrong buffer tap moves the first FIFO write away from bit 24 (or 40). The bench catches this at that single strobe. A bit-order or packing fault corrupts the first byte written, which is the address itself, so it shows within eight bits of the first exit. A stale match or first-byte flag after an abort or a restart shows one clock later on `addr_match_o` or `first_byte_o`. A filter that leaks shows as an unexpected write, at the latest 40 bits after `bof_i`.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] BCAST_ADDR = '1;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rsb_strip_buf.sv
module rsb_strip_buf
  import rsb_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 32,
  localparam int MAX_LEN  = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN,
  localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  en_i,
  input  logic  long_i,
  input  logic  bit_i,
  input  logic  bit_valid_i,
  output byte_t head_o,
  output logic  fill8_o,
  output logic  exit_valid_o,
  output logic  exit_bit_o
);
  logic [MAX_LEN-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   len;
  logic               shift;

  assign len   = long_i ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
  assign shift = en_i && bit_valid_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift) begin
      sr_q <= {sr_q[MAX_LEN-2:0], bit_i};
      if (cnt_q < len) cnt_q <= cnt_q + 1'b1;
    end
  end

  // first received bit is deepest: reverse into LSB-first address
  for (genvar i = 0; i < BYTE_W; i++) begin : g_head
    assign head_o[i] = sr_q[BYTE_W-1-i];
  end

  assign fill8_o      = cnt_q >= CNT_W'(BYTE_W);
  assign exit_valid_o = shift && (cnt_q == len);
  assign exit_bit_o   = long_i ? sr_q[LONG_LEN-1] : sr_q[SHORT_LEN-1];

  assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !fill8_o);
endmodule

// File: rtl/rsb_addr_filter.sv
module rsb_addr_filter
  import rsb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  fill8_i,
  input  byte_t head_i,
  input  byte_t station_i,
  output logic  match_o
);
  logic decided_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decided_q <= 1'b0;
      match_o   <= 1'b0;
    end else if (clr_i) begin
      decided_q <= 1'b0;
      match_o   <= 1'b0;
    end else if (fill8_i && !decided_q) begin
      decided_q <= 1'b1;
      match_o   <= (head_i == station_i) || (head_i == BCAST_ADDR);
    end
  end

  assert_match_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_q && !clr_i) |=> $stable(match_o));
endmodule

// File: rtl/rsb_byte_pack.sv
module rsb_byte_pack
  import rsb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  match_i,
  input  logic  exit_valid_i,
  input  logic  exit_bit_i,
  output logic  wr_o,
  output byte_t data_o,
  output logic  first_o
);
  localparam int BC_W = $clog2(BYTE_W);

  byte_t           sh_q;
  logic [BC_W-1:0] bcnt_q;
  byte_t           sh_nxt;

  assign sh_nxt = {exit_bit_i, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      bcnt_q  <= '0;
      wr_o    <= 1'b0;
      data_o  <= '0;
      first_o <= 1'b0;
    end else if (clr_i) begin
      sh_q    <= '0;
      bcnt_q  <= '0;
      wr_o    <= 1'b0;
      first_o <= 1'b0;
    end else begin
      wr_o <= 1'b0;
      if (exit_valid_i && match_i) begin
        sh_q   <= sh_nxt;
        bcnt_q <= bcnt_q + 1'b1;
        if (bcnt_q == BC_W'(BYTE_W - 1)) begin
          wr_o    <= 1'b1;
          data_o  <= sh_nxt;
          first_o <= 1'b1;
        end
      end
    end
  end

  assert_wr_spaced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  assert_first_with_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(first_o) |-> wr_o);
endmodule

// File: rtl/rx_strip_filter.sv
module rx_strip_filter
  import rsb_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bof_i,
  input  logic        abort_i,
  input  logic        crc_long_i,
  input  logic [7:0]  station_addr_i,
  input  logic        bit_i,
  input  logic        bit_valid_i,
  output logic        fifo_wr_o,
  output logic [7:0]  fifo_data_o,
  output logic        addr_match_o,
  output logic        first_byte_o
);
  logic  active_q;
  logic  clr;
  byte_t head;
  logic  fill8, exit_valid, exit_bit;

  assign clr = bof_i || abort_i;

  // abort wins over a simultaneous bof
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (abort_i) active_q <= 1'b0;
    else if (bof_i)   active_q <= 1'b1;
  end

  rsb_strip_buf #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_strip (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .en_i        (active_q),
    .long_i      (crc_long_i),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .head_o      (head),
    .fill8_o     (fill8),
    .exit_valid_o(exit_valid),
    .exit_bit_o  (exit_bit)
  );

  rsb_addr_filter u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .fill8_i  (fill8),
    .head_i   (head),
    .station_i(station_addr_i),
    .match_o  (addr_match_o)
  );

  rsb_byte_pack u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .match_i     (addr_match_o),
    .exit_valid_i(exit_valid),
    .exit_bit_i  (exit_bit),
    .wr_o        (fifo_wr_o),
    .data_o      (fifo_data_o),
    .first_o     (first_byte_o)
  );

  assert_wr_needs_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> addr_match_o);
  assert_abort_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !addr_match_o && !first_byte_o && !fifo_wr_o);
  assert_bof_restarts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bof_i |=> !addr_match_o && !first_byte_o && !fifo_wr_o);
  assert_wr_after_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> $past(bit_valid_i));
endmodule

// File: tb/rx_strip_filter_tb.sv
module rx_strip_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STATION = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bof_i = 1'b0, abort_i = 1'b0, crc_long_i = 1'b0;
  logic [7:0] station_addr_i = STATION;
  logic       bit_i = 1'b0, bit_valid_i = 1'b0;
  logic       fifo_wr_o, addr_match_o, first_byte_o;
  logic [7:0] fifo_data_o;

  rx_strip_filter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bof_i(bof_i), .abort_i(abort_i),
    .crc_long_i(crc_long_i), .station_addr_i(station_addr_i),
    .bit_i(bit_i), .bit_valid_i(bit_valid_i), .fifo_wr_o(fifo_wr_o),
    .fifo_data_o(fifo_data_o), .addr_match_o(addr_match_o),
    .first_byte_o(first_byte_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] exp_q[$];
  logic [7:0] pl_q[$];
  int errors = 0, checks = 0;
  int bits_sent = 0, frame_wr = 0, exp_first_at = 0;
  bit first_seen = 1'b0;
  string first_req = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial forever begin
    @(posedge clk); #1;
    if (fifo_wr_o) begin
      frame_wr++;
      if (!first_seen) begin
        first_seen = 1'b1;
        chk(bits_sent == exp_first_at, first_req, "first write bit count",
            bits_sent, exp_first_at);
      end
      if (exp_q.size() == 0)
        chk(1'b0, "R6", "unexpected write", fifo_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(fifo_data_o == e, "R3", "byte", fifo_data_o, e);
      end
    end
  end

  task automatic start_frame(input bit long_sel);
    @(negedge clk);
    bof_i = 1'b1; bit_valid_i = 1'b0; crc_long_i = long_sel;
    bits_sent = 0; frame_wr = 0; first_seen = 1'b0;
    exp_first_at = long_sel ? 40 : 24;
    first_req = long_sel ? "R7" : "R2";
  endtask

  task automatic drive_bit(input logic b, input bit gap);
    @(negedge clk);
    bof_i = 1'b0; bit_i = b; bit_valid_i = 1'b1; bits_sent++;
    if (gap) begin
      @(negedge clk);
      bit_valid_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bit_valid_i = 1'b0; bof_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // sends address, pl_q payload, then check-code bits
  task automatic send_frame(input logic [7:0] addr, input bit long_sel, input bit gap);
    bit m;
    int n;
    m = (addr == STATION) || (addr == 8'hFF);
    n = pl_q.size();
    start_frame(long_sel);
    if (m) begin
      exp_q.push_back(addr);
      foreach (pl_q[k]) exp_q.push_back(pl_q[k]);
    end
    for (int i = 0; i < 8; i++) drive_bit(addr[i], gap);
    @(negedge clk); bit_valid_i = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(addr_match_o == m, "R4", "addr match", addr_match_o, m);
    foreach (pl_q[k])
      for (int i = 0; i < 8; i++) drive_bit(pl_q[k][i], gap);
    for (int i = 0; i < (long_sel ? 32 : 16); i++) drive_bit((i % 3) == 0, gap);
    idle(4);
    chk(exp_q.size() == 0, "R6", "missing writes", exp_q.size(), 0);
    chk(frame_wr == (m ? n + 1 : 0), m ? "R6" : "R5", "write count",
        frame_wr, m ? n + 1 : 0);
    chk(first_byte_o == m, "R8", "first byte flag", first_byte_o, m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk(!fifo_wr_o && fifo_data_o == 8'h00 && !addr_match_o && !first_byte_o,
        "R1", "reset outputs", {fifo_wr_o, addr_match_o, first_byte_o}, 0);
    // R1: bits before any bof are ignored
    for (int i = 0; i < 40; i++) drive_bit(1'b1, 1'b0);
    idle(3);
    chk(frame_wr == 0 && !addr_match_o, "R1", "bits before bof", frame_wr, 0);

    // R2 R3 R6 R8: station match, short code, back-to-back bits
    pl_q = '{8'hA5, 8'h3C, 8'h81};
    send_frame(STATION, 1'b0, 1'b0);

    // R4 R10: broadcast with gaps between bits
    pl_q = '{8'h12, 8'hFE};
    send_frame(8'hFF, 1'b0, 1'b1);

    // R5: foreign address
    pl_q = '{8'h77, 8'h00, 8'h55};
    send_frame(8'h33, 1'b0, 1'b1);

    // R7: long check code
    pl_q = '{8'hC9, 8'h0F};
    send_frame(STATION, 1'b1, 1'b0);

    // R9: abort after the first byte is written
    start_frame(1'b0);
    exp_q.push_back(STATION);
    for (int i = 0; i < 8; i++) drive_bit(STATION[i], 1'b0);
    for (int i = 0; i < 16; i++) drive_bit(i[0], 1'b0);
    idle(2);
    chk(first_byte_o && frame_wr == 1, "R8", "first byte before abort", first_byte_o, 1);
    @(negedge clk); abort_i = 1'b1;
    @(posedge clk); #1;
    chk(!first_byte_o && !addr_match_o, "R9", "abort clears flags",
        {addr_match_o, first_byte_o}, 0);
    @(negedge clk); abort_i = 1'b0;
    for (int i = 0; i < 48; i++) drive_bit(i[1], 1'b0);
    idle(3);
    chk(frame_wr == 1 && !addr_match_o, "R9", "bits after abort ignored", frame_wr, 1);

    // R11: bof in the middle of a frame
    start_frame(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(STATION[i], 1'b0);
    for (int i = 0; i < 10; i++) drive_bit(1'b1, 1'b0);
    pl_q = '{8'h6D};
    send_frame(8'hFF, 1'b0, 1'b0);
    chk(addr_match_o, "R11", "restarted frame matched", addr_match_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule